// File: doc/BRIEF.md
# Identification Register Slave

This block is a small AXI4-Lite slave that lets a processor read three 32-bit identification words: a version number, a sub-version number and a board-kind code. The three words arrive on input ports and are copied into holding registers on every clock, so whatever drives those ports becomes visible to software one cycle later. Software cannot change them. Writes to any address complete normally and have no effect.

Each identification word has a companion status word. Bit 0 of the status word is a freshness flag. Reading the status word clears the flag. The next copy of the source then sets it again. Because the copy runs on every cycle, the cleared state can only be seen by a status read accepted in the very next cycle. This happens when the master issues back-to-back reads while it consumes the first response.

The slave keeps at most one read response and one write response pending. Each response is held until the master accepts it. The write address and write data may arrive in either order.

Top module: `ident_axil_regs`

## Requirements
- R1: While reset is low and in the first cycle after it, rvalid and bvalid are low and arready, awready and wready are high.
- R2: A read of word offset 0x10, 0x18 or 0x20 returns the version, sub-version or board-kind input respectively, as it stood two or more cycles before the read address handshake.
- R3: A read of status offset 0x14, 0x1C or 0x24 returns the flag of the version, sub-version or board-kind word in bit 0, with bits 31:1 zero; the flag reads 1 when no read of that status offset was accepted in the previous cycle.
- R4: A status read accepted in the cycle right after an accepted read of the same status offset returns bit 0 = 0; a read of a different status offset in that cycle still returns 1.
- R5: Reads of offsets 0x00 to 0x0C and of any offset from 0x28 upward return zero; every read response is OKAY (rresp = 2'b00).
- R6: Every write completes with bresp = 2'b00 (OKAY) and changes neither the data words nor the flags.
- R7: Once rvalid is high it stays high, with rdata unchanged, until a cycle with rready high.
- R8: Once bvalid is high it stays high until a cycle with bready high; bvalid rises only after both the address and the data of a write have been accepted, in either order.
- R9: No read address is accepted while a read response waits with rready low, and awready and wready are low while bvalid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| id_ver_i | input | 32 | Version word source |
| id_sub_i | input | 32 | Sub-version word source |
| id_kind_i | input | 32 | Board-kind word source |
| awaddr | input | 6 | Write address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | 32 | Write data (ignored) |
| wstrb | input | 4 | Write strobes (ignored) |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bresp | output | 2 | Write response |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| araddr | input | 6 | Read address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |

## Verification
The assertions check the handshake rules on every cycle:
- the held and stable read and write responses,
- the blocked address channels while a response is pending,
- the OKAY codes,
- zero data from reserved offsets,
- zero upper bits in status words.

Only the bench scenarios can show the following:
- that the right source word lands at the right offset with its one-cycle copy delay;
- that a back-to-back status read sees the cleared flag while a neighbouring flag stays set;
- that a write leaves the readable state untouched.

// File: rtl/idr_pkg.sv
package idr_pkg;
   localparam int unsigned NUM_IDS      = 3;
   localparam int unsigned ID_BASE_WORD = 4;
   localparam logic [1:0]  RESP_OKAY    = 2'b00;

   function automatic int unsigned data_word(input int unsigned k);
      return ID_BASE_WORD + 2 * k;
   endfunction

   function automatic int unsigned stat_word(input int unsigned k);
      return ID_BASE_WORD + 2 * k + 1;
   endfunction

   function automatic int unsigned last_word();
      return ID_BASE_WORD + 2 * NUM_IDS - 1;
   endfunction
endpackage

// File: rtl/idr_slot.sv
module idr_slot #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] src_i,
   input  logic              clr_i,
   output logic [DATA_W-1:0] val_o,
   output logic              flag_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_o  <= '0;
         flag_o <= 1'b0;
      end else begin
         val_o  <= src_i;
         flag_o <= !clr_i;
      end
   end
endmodule

// File: rtl/idr_wr_chan.sv
module idr_wr_chan #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   awaddr,
   input  logic                awvalid,
   output logic                awready,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [DATA_W/8-1:0] wstrb,
   input  logic                wvalid,
   output logic                wready,
   output logic [1:0]          bresp,
   output logic                bvalid,
   input  logic                bready
);
   logic aw_held, w_held, aw_now, w_now;
   logic unused_wr_bits;

   assign unused_wr_bits = ^{awaddr, wdata, wstrb};

   assign awready = !aw_held && !bvalid;
   assign wready  = !w_held  && !bvalid;
   assign aw_now  = aw_held || (awvalid && awready);
   assign w_now   = w_held  || (wvalid  && wready);
   assign bresp   = idr_pkg::RESP_OKAY;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         aw_held <= 1'b0;
         w_held  <= 1'b0;
         bvalid  <= 1'b0;
      end else if (bvalid) begin
         if (bready) bvalid <= 1'b0;
      end else if (aw_now && w_now) begin
         bvalid  <= 1'b1;
         aw_held <= 1'b0;
         w_held  <= 1'b0;
      end else begin
         aw_held <= aw_now;
         w_held  <= w_now;
      end
   end
endmodule

// File: rtl/idr_rd_chan.sv
module idr_rd_chan #(
   parameter int unsigned ADDR_W  = 6,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned NUM_IDS = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [ADDR_W-1:0]               araddr,
   input  logic                            arvalid,
   output logic                            arready,
   output logic [DATA_W-1:0]               rdata,
   output logic [1:0]                      rresp,
   output logic                            rvalid,
   input  logic                            rready,
   input  logic [NUM_IDS-1:0][DATA_W-1:0]  vals_i,
   input  logic [NUM_IDS-1:0]              flags_i,
   output logic [NUM_IDS-1:0]              clr_o
);
   localparam int unsigned WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] ar_word;
   logic              ar_hs;
   logic [DATA_W-1:0] rd_next;
   logic [1:0]        unused_lsb;

   assign unused_lsb = araddr[1:0];
   assign ar_word    = araddr[ADDR_W-1:2];
   assign arready    = !rvalid || rready;
   assign ar_hs      = arvalid && arready;
   assign rresp      = idr_pkg::RESP_OKAY;

   always_comb begin
      rd_next = '0;
      for (int unsigned k = 0; k < NUM_IDS; k++) begin
         if (ar_word == WORD_W'(idr_pkg::data_word(k))) rd_next = vals_i[k];
         if (ar_word == WORD_W'(idr_pkg::stat_word(k)))
            rd_next = {{(DATA_W-1){1'b0}}, flags_i[k]};
      end
   end

   for (genvar g = 0; g < NUM_IDS; g++) begin : g_clr
      assign clr_o[g] = ar_hs && (ar_word == WORD_W'(idr_pkg::stat_word(g)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= '0;
      end else if (ar_hs) begin
         rvalid <= 1'b1;
         rdata  <= rd_next;
      end else if (rready) begin
         rvalid <= 1'b0;
      end
   end
endmodule

// File: rtl/ident_axil_regs.sv
module ident_axil_regs #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [DATA_W-1:0]   id_ver_i,
   input  logic [DATA_W-1:0]   id_sub_i,
   input  logic [DATA_W-1:0]   id_kind_i,
   input  logic [ADDR_W-1:0]   awaddr,
   input  logic                awvalid,
   output logic                awready,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [DATA_W/8-1:0] wstrb,
   input  logic                wvalid,
   output logic                wready,
   output logic [1:0]          bresp,
   output logic                bvalid,
   input  logic                bready,
   input  logic [ADDR_W-1:0]   araddr,
   input  logic                arvalid,
   output logic                arready,
   output logic [DATA_W-1:0]   rdata,
   output logic [1:0]          rresp,
   output logic                rvalid,
   input  logic                rready
);
   localparam int unsigned NUM_IDS = idr_pkg::NUM_IDS;

   if (((idr_pkg::last_word() + 1) * 4) > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("DATA_W must be 32");
   end

   logic [NUM_IDS-1:0][DATA_W-1:0] src, vals;
   logic [NUM_IDS-1:0]             flags, clr;

   assign src[0] = id_ver_i;
   assign src[1] = id_sub_i;
   assign src[2] = id_kind_i;

   for (genvar g = 0; g < NUM_IDS; g++) begin : g_slot
      idr_slot #(.DATA_W(DATA_W)) u_slot (
         .clk    (clk),
         .rst_n  (rst_n),
         .src_i  (src[g]),
         .clr_i  (clr[g]),
         .val_o  (vals[g]),
         .flag_o (flags[g])
      );
   end

   idr_rd_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_IDS(NUM_IDS)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .araddr  (araddr),
      .arvalid (arvalid),
      .arready (arready),
      .rdata   (rdata),
      .rresp   (rresp),
      .rvalid  (rvalid),
      .rready  (rready),
      .vals_i  (vals),
      .flags_i (flags),
      .clr_o   (clr)
   );

   idr_wr_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
      .clk     (clk),
      .rst_n   (rst_n),
      .awaddr  (awaddr),
      .awvalid (awvalid),
      .awready (awready),
      .wdata   (wdata),
      .wstrb   (wstrb),
      .wvalid  (wvalid),
      .wready  (wready),
      .bresp   (bresp),
      .bvalid  (bvalid),
      .bready  (bready)
   );
endmodule

// File: rtl/ident_axil_regs_chk.sv
module ident_axil_regs_chk #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] araddr,
   input logic              arvalid,
   input logic              arready,
   input logic [DATA_W-1:0] rdata,
   input logic [1:0]        rresp,
   input logic              rvalid,
   input logic              rready,
   input logic              awready,
   input logic              wready,
   input logic [1:0]        bresp,
   input logic              bvalid,
   input logic              bready
);
   localparam int unsigned WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   logic              ar_hs, is_stat, is_resv;

   assign word    = araddr[ADDR_W-1:2];
   assign ar_hs   = arvalid && arready;
   assign is_resv = (int'(word) < int'(idr_pkg::ID_BASE_WORD)) ||
                    (int'(word) > int'(idr_pkg::last_word()));

   always_comb begin
      is_stat = 1'b0;
      for (int unsigned k = 0; k < idr_pkg::NUM_IDS; k++)
         if (word == WORD_W'(idr_pkg::stat_word(k))) is_stat = 1'b1;
   end

   // R7
   rvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid && !rready |=> rvalid && $stable(rdata));

   // R8
   bvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bvalid && !bready |=> bvalid);

   // R9
   ar_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid && !rready |-> !arready);

   // R9
   w_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bvalid |-> !awready && !wready);

   // R6
   bresp_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bvalid |-> bresp == 2'b00);

   // R5
   rresp_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |-> rresp == 2'b00);

   // R5
   resv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ar_hs && is_resv |=> rdata == '0);

   // R3
   stat_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ar_hs && is_stat |=> rdata[DATA_W-1:1] == '0);
endmodule

bind ident_axil_regs ident_axil_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .araddr  (araddr),
   .arvalid (arvalid),
   .arready (arready),
   .rdata   (rdata),
   .rresp   (rresp),
   .rvalid  (rvalid),
   .rready  (rready),
   .awready (awready),
   .wready  (wready),
   .bresp   (bresp),
   .bvalid  (bvalid),
   .bready  (bready)
);

// File: tb/sim_ident_axil_regs.sv
module sim_ident_axil_regs;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] id_ver_i = 32'h0102_0304, id_sub_i = 32'h0000_0007, id_kind_i = 32'hB0A2_0001;
   logic [5:0]  awaddr = '0, araddr = '0;
   logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
   logic [31:0] wdata = '0;
   logic [3:0]  wstrb = '0;
   logic        awready, wready, bvalid, arready, rvalid;
   logic [1:0]  bresp, rresp;
   logic [31:0] rdata;
   int          n_chk = 0, n_fail = 0;
   bit          done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ident_axil_regs u0 (.*);

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk); araddr = a; arvalid = 1; rready = 1;
      while (!arready) @(negedge clk);
      @(negedge clk); arvalid = 0;
      while (!rvalid) @(negedge clk);
      d = rdata;
      check("R5 rresp", {30'd0, rresp}, 32'd0);
      @(negedge clk);
   endtask

   task automatic rd2(input logic [5:0] a1, a2, output logic [31:0] d1, d2);
      @(negedge clk); araddr = a1; arvalid = 1; rready = 1;
      @(negedge clk); d1 = rdata; araddr = a2;
      check("R4 back-to-back accept", {31'd0, arready}, 32'd1);
      @(negedge clk); arvalid = 0; d2 = rdata;
      @(negedge clk);
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk); awaddr = a; wdata = d; wstrb = 4'hF; awvalid = 1; wvalid = 1; bready = 1;
      @(negedge clk); awvalid = 0; wvalid = 0;
      check("R6 bvalid", {31'd0, bvalid}, 32'd1);
      check("R6 bresp", {30'd0, bresp}, 32'd0);
      @(negedge clk); bready = 0;
   endtask

   task automatic t_reset();
      check("R1 rvalid", {31'd0, rvalid}, 0);
      check("R1 bvalid", {31'd0, bvalid}, 0);
      check("R1 readies", {29'd0, arready, awready, wready}, 32'd7);
      @(negedge clk); rst_n = 1;
      check("R1 rvalid after", {31'd0, rvalid}, 0);
      check("R1 readies after", {29'd0, arready, awready, wready}, 32'd7);
   endtask

   task automatic t_data();
      logic [31:0] d;
      rd(6'h10, d); check("R2 version", d, 32'h0102_0304);
      rd(6'h18, d); check("R2 subversion", d, 32'h0000_0007);
      rd(6'h20, d); check("R2 board kind", d, 32'hB0A2_0001);
      @(negedge clk); id_ver_i = 32'hCAFE_0042; id_kind_i = 32'h0000_FFFF;
      @(negedge clk);
      rd(6'h10, d); check("R2 version updated", d, 32'hCAFE_0042);
      rd(6'h20, d); check("R2 kind updated", d, 32'h0000_FFFF);
   endtask

   task automatic t_status();
      logic [31:0] d, e;
      rd(6'h14, d); check("R3 version flag", d, 1);
      rd(6'h1C, d); check("R3 sub flag", d, 1);
      rd(6'h24, d); check("R3 kind flag", d, 1);
      rd2(6'h14, 6'h14, d, e);
      check("R4 first read", d, 1); check("R4 cleared", e, 0);
      rd2(6'h24, 6'h1C, d, e);
      check("R4 first kind", d, 1); check("R4 other flag kept", e, 1);
      rd(6'h14, d); check("R3 flag re-set", d, 1);
   endtask

   task automatic t_reserved();
      logic [31:0] d;
      for (int a = 0; a < 16; a += 4) begin
         rd(6'(a), d); check("R5 reserved", d, 0);
      end
      rd(6'h28, d); check("R5 unmapped 0x28", d, 0);
      rd(6'h3C, d); check("R5 unmapped 0x3C", d, 0);
   endtask

   task automatic t_write_ignored();
      logic [31:0] d;
      wr(6'h10, 32'hDEAD_BEEF);
      wr(6'h14, 32'h0);
      wr(6'h24, 32'h0);
      rd(6'h10, d); check("R6 version unchanged", d, 32'hCAFE_0042);
      rd(6'h14, d); check("R6 flag unchanged", d, 1);
      rd(6'h24, d); check("R6 kind flag unchanged", d, 1);
   endtask

   task automatic t_rhold();
      logic [31:0] d;
      @(negedge clk); araddr = 6'h18; arvalid = 1; rready = 0;
      @(negedge clk); arvalid = 0; d = rdata; id_sub_i = 32'h1234_5678;
      check("R7 rvalid", {31'd0, rvalid}, 1);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R7 rvalid held", {31'd0, rvalid}, 1);
         check("R7 rdata stable", rdata, d);
         check("R9 arready low", {31'd0, arready}, 0);
      end
      rready = 1;
      @(negedge clk);
      check("R7 released", {31'd0, rvalid}, 0);
   endtask

   task automatic t_bhold();
      @(negedge clk); awaddr = 6'h20; awvalid = 1; bready = 0;
      @(negedge clk); awvalid = 0;
      check("R8 no bvalid addr only", {31'd0, bvalid}, 0);
      @(negedge clk);
      check("R8 still no bvalid", {31'd0, bvalid}, 0);
      wvalid = 1;
      @(negedge clk); wvalid = 0;
      check("R8 bvalid", {31'd0, bvalid}, 1);
      check("R9 aw/w ready low", {30'd0, awready, wready}, 0);
      @(negedge clk); @(negedge clk);
      check("R8 bvalid held", {31'd0, bvalid}, 1);
      bready = 1;
      @(negedge clk); bready = 0;
      check("R8 released", {31'd0, bvalid}, 0);
      wvalid = 1;
      @(negedge clk); wvalid = 0;
      check("R8 no bvalid data only", {31'd0, bvalid}, 0);
      awvalid = 1;
      @(negedge clk); awvalid = 0;
      check("R8 bvalid data first", {31'd0, bvalid}, 1);
      bready = 1;
      @(negedge clk); bready = 0;
      check("R8 released data first", {31'd0, bvalid}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_data();
      t_status();
      t_reserved();
      t_write_ignored();
      t_rhold();
      t_bhold();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule